// File: doc/BRIEF.md
# CEC Transmit Frame Stager

This block is the transmit front end of a serial consumer-electronics control bus controller. Software programs a frame through a small word-addressed register port: the initiator address, the destination address, an opcode and up to fourteen operand bytes. Writing the operand count with its go bit set launches the frame. A one-byte polling frame, which carries only the address header, is launched instead by writing the destination register with its header-only flag set.

While a frame is in flight the block presents one byte at a time to a bit-level line engine and waits for that engine to report each byte as finished, together with a negative-acknowledge flag and an arbitration-lost flag. Either flag marks the whole attempt as failed, and the frame is sent again from the header byte until a programmed attempt limit is used up. The block ends each frame with a success flag or an attempts-exhausted flag. Each flag has an enable, and the enabled flags drive a single interrupt line. A self-clearing flush control empties the staged payload between frames.

Top module: `cec_tx_stager`

## Requirements
- R1: After synchronous reset, tx_valid and irq are low, and the control register (address 0x04), both status registers (0x05, 0x06) and all staging registers read zero.
- R2: A normal frame is presented in this order: header byte {initiator[3:0], destination[3:0]}, then the opcode (0x02), then operands 0..N-1 from addresses 0x10+k. tx_last is high only on the final byte. Each byte holds stable until byte_done.
- R3: When the block is idle, a write to the destination register (0x01) with bit 7 set starts a one-byte frame made of the header alone, with tx_last high.
- R4: When the block is idle, a write to the count register (0x03) with bit 4 set starts a normal frame with N = bits 3:0. A count above 14 is stored and used as 14. A count write with bit 4 clear only stores the count.
- R5: A byte_done with byte_nack or arb_lost fails the attempt, and the next byte presented is the header again. At most retry+1 attempts are made, where retry is control bits 6:4.
- R6: When the last allowed attempt fails, the block goes idle and sets bit 1 of status register 1 (0x06). Control bits 6:4 then read the number of attempts used minus one.
- R7: A byte_done on the final byte with neither flag set ends the frame and sets bit 5 of status register 0 (0x05).
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A flag set in the same cycle wins over the clear.
- R9: irq is high exactly when (status0 bit 5 AND enable0 bit 5, address 0x07) OR (status1 bit 1 AND enable1 bit 1, address 0x08).
- R10: While a frame is in flight, writes to the initiator, destination, opcode, count, operand and control registers have no effect. Control bit 0 reads 1 while busy and 0 otherwise.
- R11: When idle, writing control bit 7 sets a flush that reads 1 for one cycle, then clears by itself and leaves the opcode, count and operand registers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| tx_valid | output | 1 | A byte is offered to the line engine (block busy) |
| tx_byte | output | 8 | Byte offered to the line engine |
| tx_last | output | 1 | Offered byte is the last of the frame |
| byte_done | input | 1 | Line engine finished the offered byte |
| byte_nack | input | 1 | Byte was negatively acknowledged (valid with byte_done) |
| arb_lost | input | 1 | Arbitration was lost (valid with byte_done) |
| irq | output | 1 | Enabled status flags, ORed |

## Verification
On every cycle, the assertions check that an offered byte holds still until it is consumed, that a failed attempt either restarts at the header or raises the exhaustion flag, that a clean final byte ends the frame with the success flag, that the header registers are frozen in flight, that the flush control clears by itself, and that the interrupt line agrees with the flags. Only the bench's scenarios can show the full byte order of a frame, the clamping of the count, the exact number of attempts before exhaustion and the reported attempt count, that writes made during a frame leave every readable register unchanged, and that a flush empties the payload.

// File: rtl/cec_tx_pkg.sv
// Package: register addresses and sequencer state shared by the stager blocks.
// Assumes a 5-bit word address and byte-wide registers.
package cec_tx_pkg;
    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int TRY_W  = 3;

    localparam logic [ADDR_W-1:0] A_INIT   = 5'h00;
    localparam logic [ADDR_W-1:0] A_DEST   = 5'h01;
    localparam logic [ADDR_W-1:0] A_OPCODE = 5'h02;
    localparam logic [ADDR_W-1:0] A_COUNT  = 5'h03;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h04;
    localparam logic [ADDR_W-1:0] A_STAT0  = 5'h05;
    localparam logic [ADDR_W-1:0] A_STAT1  = 5'h06;
    localparam logic [ADDR_W-1:0] A_EN0    = 5'h07;
    localparam logic [ADDR_W-1:0] A_EN1    = 5'h08;
    localparam logic [ADDR_W-1:0] A_OPND0  = 5'h10;

    localparam int DONE_BIT = 5;
    localparam int FAIL_BIT = 1;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;
endpackage

// File: rtl/cec_tx_regs.sv
// Staging register file: initiator, destination, opcode, count, operands,
// retry limit and flush control. Accepts writes only while idle and not
// flushing; produces the one-cycle start request. Assumes MAX_OPS <= 15.
module cec_tx_regs
    import cec_tx_pkg::*;
#(
    parameter int MAX_OPS = 14
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [BYTE_W-1:0]               wdata,
    input  logic                            busy,
    input  logic                            fail_evt,
    input  logic [TRY_W-1:0]                fail_tries,
    output logic [3:0]                      init_q,
    output logic [BYTE_W-1:0]               dest_q,
    output logic [BYTE_W-1:0]               opcode_q,
    output logic [MAX_OPS-1:0][BYTE_W-1:0]  opnd_q,
    output logic [CNT_W-1:0]                count_q,
    output logic                            poll_q,
    output logic [TRY_W-1:0]                retry_q,
    output logic                            flush_q,
    output logic                            start
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OPS);

    logic             idle_wr;
    logic [CNT_W-1:0] cnt_clamped;

    // Writes land only when no frame is in flight and no flush is pending.
    assign idle_wr     = wr && !busy && !flush_q;
    assign cnt_clamped = (wdata[CNT_W-1:0] > CNT_MAX) ? CNT_MAX : wdata[CNT_W-1:0];

    // Start request: go bit on a count write, or header-only flag on a destination write.
    assign start = idle_wr && (((addr == A_COUNT) && wdata[4]) ||
                               ((addr == A_DEST)  && wdata[7]));

    // Staging storage, flush clearing and failure attempt report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q   <= '0;
            dest_q   <= '0;
            opcode_q <= '0;
            opnd_q   <= '0;
            count_q  <= '0;
            poll_q   <= 1'b0;
            retry_q  <= '0;
            flush_q  <= 1'b0;
        end else begin
            if (flush_q) begin
                opcode_q <= '0;
                opnd_q   <= '0;
                count_q  <= '0;
                flush_q  <= 1'b0;
            end else if (idle_wr) begin
                case (addr)
                    A_INIT:   init_q <= wdata[3:0];
                    A_DEST: begin
                        dest_q <= wdata;
                        if (wdata[7]) poll_q <= 1'b1;
                    end
                    A_OPCODE: opcode_q <= wdata;
                    A_COUNT: begin
                        count_q <= cnt_clamped;
                        if (wdata[4]) poll_q <= 1'b0;
                    end
                    A_CTRL: begin
                        retry_q <= wdata[6:4];
                        flush_q <= wdata[7];
                    end
                    default: begin
                        for (int k = 0; k < MAX_OPS; k++) begin
                            if (addr == A_OPND0 + ADDR_W'(k)) opnd_q[k] <= wdata;
                        end
                    end
                endcase
            end
            if (fail_evt) retry_q <= fail_tries;
        end
    end
endmodule

// File: rtl/cec_tx_seq.sv
// Frame sequencer: walks the byte index of the staged frame, consumes one
// byte per byte_done, restarts from the header after a failed attempt and
// stops after the last allowed attempt. Assumes staging is frozen while busy.
module cec_tx_seq
    import cec_tx_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              poll,
    input  logic [CNT_W-1:0]  count,
    input  logic [TRY_W-1:0]  retry_lim,
    input  logic              byte_done,
    input  logic              byte_nack,
    input  logic              arb_lost,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic              last,
    output logic              done_evt,
    output logic              fail_evt,
    output logic [TRY_W-1:0]  tries_q
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] last_idx;
    logic             bad;

    // Final byte index: header only, or header + opcode + count operands.
    assign last_idx = poll ? '0 : (IDX_W'(count) + IDX_W'(1));
    assign busy     = (state_q == SEQ_SEND);
    assign last     = busy && (idx == last_idx);
    assign bad      = busy && byte_done && (byte_nack || arb_lost);
    assign done_evt = busy && byte_done && !(byte_nack || arb_lost) && last;
    assign fail_evt = bad && (tries_q == retry_lim);

    // Attempt and byte-position tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx     <= '0;
            tries_q <= '0;
        end else if (!busy) begin
            if (start) begin
                state_q <= SEQ_SEND;
                idx     <= '0;
                tries_q <= '0;
            end
        end else if (byte_done) begin
            if (bad) begin
                if (tries_q == retry_lim) begin
                    state_q <= SEQ_IDLE;
                end else begin
                    tries_q <= tries_q + TRY_W'(1);
                    idx     <= '0;
                end
            end else if (last) begin
                state_q <= SEQ_IDLE;
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/cec_tx_irq.sv
// Interrupt flags: success and exhaustion flags with write-one-to-clear,
// their enable registers, and the combined interrupt line. A set event
// in the same cycle as a clear leaves the flag set.
module cec_tx_irq
    import cec_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               done_evt,
    input  logic               fail_evt,
    output logic               done_st,
    output logic               fail_st,
    output logic [BYTE_W-1:0]  en0_q,
    output logic [BYTE_W-1:0]  en1_q,
    output logic               irq
);
    logic clr_done, clr_fail;

    assign clr_done = wr && (addr == A_STAT0) && wdata[DONE_BIT];
    assign clr_fail = wr && (addr == A_STAT1) && wdata[FAIL_BIT];

    // Flag set/clear and enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_st <= 1'b0;
            fail_st <= 1'b0;
            en0_q   <= '0;
            en1_q   <= '0;
        end else begin
            done_st <= done_evt || (done_st && !clr_done);
            fail_st <= fail_evt || (fail_st && !clr_fail);
            if (wr && (addr == A_EN0)) en0_q <= wdata;
            if (wr && (addr == A_EN1)) en1_q <= wdata;
        end
    end

    assign irq = (done_st && en0_q[DONE_BIT]) || (fail_st && en1_q[FAIL_BIT]);
endmodule

// File: rtl/cec_tx_stager.sv
// Top of the transmit frame stager: ties the staging registers, the frame
// sequencer and the interrupt flags together, selects the byte offered to
// the line engine and decodes register reads. Assumes the line engine
// samples byte_nack and arb_lost only with byte_done.
module cec_tx_stager
    import cec_tx_pkg::*;
#(
    parameter int MAX_OPS = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [4:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               tx_valid,
    output logic [7:0]         tx_byte,
    output logic               tx_last,
    input  logic               byte_done,
    input  logic               byte_nack,
    input  logic               arb_lost,
    output logic               irq
);
    localparam int IDX_W = $clog2(MAX_OPS + 3);

    logic [3:0]                      init_q;
    logic [BYTE_W-1:0]               dest_q;
    logic [BYTE_W-1:0]               opcode_q;
    logic [MAX_OPS-1:0][BYTE_W-1:0]  opnd_q;
    logic [CNT_W-1:0]                count_q;
    logic                            poll_q;
    logic [TRY_W-1:0]                retry_q;
    logic                            flush_q;
    logic                            start;
    logic                            busy;
    logic [IDX_W-1:0]                idx;
    logic                            done_evt, fail_evt;
    logic [TRY_W-1:0]                tries_q;
    logic                            done_st, fail_st;
    logic [BYTE_W-1:0]               en0_q, en1_q;
    logic [BYTE_W-1:0]               hdr_w;

    cec_tx_regs #(.MAX_OPS(MAX_OPS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .fail_evt(fail_evt), .fail_tries(tries_q),
        .init_q(init_q), .dest_q(dest_q), .opcode_q(opcode_q), .opnd_q(opnd_q),
        .count_q(count_q), .poll_q(poll_q), .retry_q(retry_q), .flush_q(flush_q),
        .start(start)
    );

    cec_tx_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .poll(poll_q), .count(count_q),
        .retry_lim(retry_q), .byte_done(byte_done), .byte_nack(byte_nack),
        .arb_lost(arb_lost), .busy(busy), .idx(idx), .last(tx_last),
        .done_evt(done_evt), .fail_evt(fail_evt), .tries_q(tries_q)
    );

    cec_tx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .done_evt(done_evt), .fail_evt(fail_evt), .done_st(done_st),
        .fail_st(fail_st), .en0_q(en0_q), .en1_q(en1_q), .irq(irq)
    );

    assign hdr_w    = {init_q, dest_q[3:0]};
    assign tx_valid = busy;

    // Byte selection: header, opcode, then operands by sequencer index.
    always_comb begin
        tx_byte = '0;
        if (idx == '0) begin
            tx_byte = hdr_w;
        end else if (idx == IDX_W'(1)) begin
            tx_byte = opcode_q;
        end else begin
            for (int k = 0; k < MAX_OPS; k++) begin
                if (idx == IDX_W'(k + 2)) tx_byte = opnd_q[k];
            end
        end
    end

    // Register read decode.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_INIT:   reg_rdata = {4'b0, init_q};
            A_DEST:   reg_rdata = dest_q;
            A_OPCODE: reg_rdata = opcode_q;
            A_COUNT:  reg_rdata = {{(BYTE_W-CNT_W){1'b0}}, count_q};
            A_CTRL:   reg_rdata = {flush_q, retry_q, 3'b0, busy};
            A_STAT0:  reg_rdata = BYTE_W'(done_st) << DONE_BIT;
            A_STAT1:  reg_rdata = BYTE_W'(fail_st) << FAIL_BIT;
            A_EN0:    reg_rdata = en0_q;
            A_EN1:    reg_rdata = en1_q;
            default: begin
                for (int k = 0; k < MAX_OPS; k++) begin
                    if (reg_addr == A_OPND0 + ADDR_W'(k)) reg_rdata = opnd_q[k];
                end
            end
        endcase
    end
endmodule

// File: rtl/cec_tx_chk.sv
// Checker for the transmit frame stager: temporal properties over the
// line-engine handshake, the flags, the header registers and the flush bit.
module cec_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       tx_last,
    input logic       byte_done,
    input logic       byte_nack,
    input logic       arb_lost,
    input logic       irq,
    input logic [7:0] tx_hdr,
    input logic       st_done,
    input logic       st_fail,
    input logic       en_done,
    input logic       en_fail,
    input logic       flush_q
);
    assert_hold_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !byte_done |=> tx_valid && $stable(tx_byte));

    assert_restart_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && byte_done && (byte_nack || arb_lost) |=> !tx_valid || (tx_byte == tx_hdr));

    assert_exhaust_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && byte_done && (byte_nack || arb_lost) |=> tx_valid || st_fail);

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && byte_done && tx_last && !byte_nack && !arb_lost |=> !tx_valid && st_done);

    assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && en_done) || (st_fail && en_fail) |-> irq);

    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_done && !st_fail |-> !irq);

    assert_hdr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && $past(tx_valid) |-> $stable(tx_hdr));

    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |=> !flush_q);
endmodule

bind cec_tx_stager cec_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_last(tx_last), .byte_done(byte_done), .byte_nack(byte_nack),
    .arb_lost(arb_lost), .irq(irq), .tx_hdr(hdr_w), .st_done(done_st),
    .st_fail(fail_st), .en_done(en0_q[5]), .en_fail(en1_q[1]), .flush_q(flush_q)
);

// File: tb/cec_tx_stager_test.sv
// Bench: behavioural reference model updated on every rising edge and
// compared against the stager's outputs on every falling edge, plus
// register read-back checks. Includes a simple line-engine responder.
module cec_tx_stager_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_valid, tx_last, irq;
    logic [7:0] tx_byte;
    logic       byte_done = 1'b0, byte_nack = 1'b0, arb_lost = 1'b0;

    int vectors = 0, miscompares = 0;
    bit run = 0;

    // engine responder configuration
    int fails_left = 0, fail_at = 0, eb = 0;
    bit use_arb = 0;

    // reference model state
    int m_init, m_dest, m_opc, m_cnt, m_retry, m_en0, m_en1, m_pos, m_try;
    int m_ops[14];
    bit m_flush, m_done, m_fail, m_busy;
    int m_q[$];

    always #2 clk = ~clk;

    cec_tx_stager uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_last(tx_last), .byte_done(byte_done),
        .byte_nack(byte_nack), .arb_lost(arb_lost), .irq(irq)
    );

    function automatic int m_read(input int a);
        if (a == 0) return m_init;
        if (a == 1) return m_dest;
        if (a == 2) return m_opc;
        if (a == 3) return m_cnt;
        if (a == 4) return (int'(m_flush) << 7) | (m_retry << 4) | int'(m_busy);
        if (a == 5) return int'(m_done) << 5;
        if (a == 6) return int'(m_fail) << 1;
        if (a == 7) return m_en0;
        if (a == 8) return m_en1;
        if (a >= 16 && a < 30) return m_ops[a-16];
        return 0;
    endfunction

    function automatic bit m_irq();
        return (m_done && m_en0[5]) || (m_fail && m_en1[1]);
    endfunction

    // Reference model: one update per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_init = 0; m_dest = 0; m_opc = 0; m_cnt = 0; m_retry = 0;
            m_en0 = 0; m_en1 = 0; m_pos = 0; m_try = 0;
            m_flush = 0; m_done = 0; m_fail = 0; m_busy = 0;
            foreach (m_ops[i]) m_ops[i] = 0;
            m_q.delete();
        end else begin
            automatic bit busy_pre = m_busy;
            automatic bit flush_pre = m_flush;
            automatic int d = reg_wdata;
            if (flush_pre) begin
                m_opc = 0; m_cnt = 0; m_flush = 0;
                foreach (m_ops[i]) m_ops[i] = 0;
            end
            if (reg_wr) begin
                if (reg_addr == 5 && d[5]) m_done = 0;
                if (reg_addr == 6 && d[1]) m_fail = 0;
                if (reg_addr == 7) m_en0 = d;
                if (reg_addr == 8) m_en1 = d;
                if (!busy_pre && !flush_pre) begin
                    case (int'(reg_addr))
                        0: m_init = d & 15;
                        1: begin
                            m_dest = d;
                            if (d[7]) begin
                                m_q.delete();
                                m_q.push_back((m_init << 4) | (d & 15));
                                m_busy = 1; m_pos = 0; m_try = 0;
                            end
                        end
                        2: m_opc = d;
                        3: begin
                            m_cnt = ((d & 15) > 14) ? 14 : (d & 15);
                            if (d[4]) begin
                                m_q.delete();
                                m_q.push_back((m_init << 4) | (m_dest & 15));
                                m_q.push_back(m_opc);
                                for (int i = 0; i < m_cnt; i++) m_q.push_back(m_ops[i]);
                                m_busy = 1; m_pos = 0; m_try = 0;
                            end
                        end
                        4: begin m_retry = (d >> 4) & 7; m_flush = d[7]; end
                        default: if (reg_addr >= 16 && reg_addr < 30) m_ops[reg_addr-16] = d;
                    endcase
                end
            end
            if (busy_pre && byte_done) begin
                if (byte_nack || arb_lost) begin
                    if (m_try == m_retry) begin m_busy = 0; m_fail = 1; end
                    else begin m_try++; m_pos = 0; end
                end else if (m_pos == m_q.size() - 1) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_pos++;
                end
            end
        end
    end

    // Per-cycle comparison, then the line-engine response for the next edge.
    always @(negedge clk) begin
        if (run) begin
            vectors++;
            if (tx_valid !== m_busy) begin
                miscompares++;
                $display("FAIL R10 tx_valid: actual %b expected %b", tx_valid, m_busy);
            end
            if (irq !== m_irq()) begin
                miscompares++;
                $display("FAIL R9 irq: actual %b expected %b", irq, m_irq());
            end
            if (m_busy && tx_valid === 1'b1) begin
                if (tx_byte !== 8'(m_q[m_pos]) ||
                    tx_last !== (m_pos == m_q.size() - 1)) begin
                    miscompares++;
                    $display("FAIL R2 byte/last: actual %h/%b expected %h/%b",
                             tx_byte, tx_last, 8'(m_q[m_pos]), (m_pos == m_q.size() - 1));
                end
            end
        end
        if (byte_done) begin
            byte_done = 0; byte_nack = 0; arb_lost = 0;
        end else if (tx_valid === 1'b1) begin
            byte_done = 1;
            if (fails_left > 0 && (eb == fail_at || tx_last)) begin
                if (use_arb) arb_lost = 1; else byte_nack = 1;
                fails_left--; eb = 0;
            end else begin
                eb = tx_last ? 0 : eb + 1;
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 5'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input int a, input string tag);
        automatic int exp = m_read(a);
        reg_addr = 5'(a);
        #1;
        vectors++;
        if (reg_rdata !== 8'(exp)) begin
            miscompares++;
            $display("FAIL %s read addr %0h: actual %h expected %h", tag, a, reg_rdata, 8'(exp));
        end
    endtask

    task automatic want(input bit c, input string tag, input int act, input int exp);
        vectors++;
        if (!c) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        run = 1;
        @(negedge clk);
        // R1: reset state
        rd_chk(4, "R1"); rd_chk(5, "R1"); rd_chk(6, "R1"); rd_chk(2, "R1"); rd_chk(16, "R1");
        want(tx_valid === 1'b0 && irq === 1'b0, "R1 outputs idle", tx_valid, 0);

        // R2 R7 R9: normal frame with three operands
        wr(7, 8'h20); wr(8, 8'h02);
        wr(0, 4); wr(1, 0); wr(2, 8'h36); wr(16, 8'hA1); wr(17, 8'hB2); wr(18, 8'hC3);
        wr(4, 8'h20);
        wr(3, 8'h13);
        wait_idle();
        rd_chk(5, "R7"); want(irq === 1'b1, "R9 irq after success", irq, 1);
        // R8: write-one-to-clear, write zero has no effect
        wr(5, 8'h00); rd_chk(5, "R8");
        wr(5, 8'h20); rd_chk(5, "R8"); want(irq === 1'b0, "R8 irq cleared", irq, 0);

        // R4: count write without go bit only stores
        wr(3, 8'h05); rd_chk(3, "R4"); rd_chk(4, "R4");
        repeat (4) @(negedge clk);
        want(tx_valid === 1'b0, "R4 no start without go", tx_valid, 0);

        // R3: header-only frame
        wr(1, 8'h8F);
        wait_idle();
        rd_chk(5, "R3"); wr(5, 8'h20);

        // R5: one failed attempt at the opcode, then success
        wr(1, 8'h05);
        fails_left = 1; fail_at = 1; use_arb = 0; eb = 0;
        wr(3, 8'h12);
        wait_idle();
        rd_chk(5, "R5"); rd_chk(6, "R5"); wr(5, 8'h20);

        // R6: arbitration lost on every attempt, retry field 1
        wr(4, 8'h10);
        fails_left = 5; fail_at = 0; use_arb = 1; eb = 0;
        wr(3, 8'h11);
        wait_idle();
        fails_left = 0; use_arb = 0;
        rd_chk(6, "R6"); rd_chk(4, "R6"); want(irq === 1'b1, "R6 irq", irq, 1);
        wr(6, 8'h02); rd_chk(6, "R8");

        // R4 R10: clamped count, writes during flight ignored
        for (int k = 0; k < 14; k++) wr(16 + k, 8'h40 + k);
        wr(3, 8'h1F);
        rd_chk(4, "R10");
        wr(0, 9); wr(2, 8'h77); wr(17, 8'hEE); wr(3, 8'h02); wr(4, 8'h70);
        rd_chk(0, "R10"); rd_chk(2, "R10"); rd_chk(17, "R10"); rd_chk(3, "R4");
        wait_idle();
        rd_chk(4, "R10"); rd_chk(0, "R10"); wr(5, 8'h20);

        // R9: success flag with its enable off keeps irq low
        wr(7, 8'h00);
        wr(1, 8'h83);
        wait_idle();
        rd_chk(5, "R9"); want(irq === 1'b0, "R9 irq masked", irq, 0);
        wr(5, 8'h20);

        // R11: flush self-clears and empties the payload
        wr(4, 8'h80);
        rd_chk(4, "R11");
        @(negedge clk);
        rd_chk(4, "R11"); rd_chk(2, "R11"); rd_chk(3, "R11"); rd_chk(20, "R11"); rd_chk(0, "R11");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule